// File: doc/BRIEF.md
# Shared Interrupt Line Controller

This block collects a parameterised set of external interrupt lines and hands each one to exactly one core of a small multi-core cluster. Software sets it up through a flat 32-bit register window: each line gets a sense polarity, a level-or-edge trigger choice, a dual-edge enable and a mask bit. The mask bit is never written directly. Software writes ones to a mask-enable word to turn lines on and ones to a mask-disable word to turn them off.

Each line carries a core selection, held one-hot, and an optional output-pin assignment. For every core the block raises a request while any line routed to that core is both pending and unmasked. A per-core register reports the lowest-numbered such line, so the interrupt handler can find its source without a software scan. A single command register clears the latched pending bit of an edge-triggered line. The same register can also set that bit, which lets one core signal another.

Top module: `shirq_ctrl`

## Requirements
- R1: After reset every line is active-high (polarity bit 1), level-triggered (trigger bit 0), dual-edge off and masked, routed to core 0 (route value 1), with its pin assignment disabled. No line is pending and no request output is high.
- R2: A write to the mask-enable word (byte offset 0x090 + 4·w) sets the mask bit of every line in word w whose data bit is 1. A write to the mask-disable word (0x0B0 + 4·w) clears those bits. Lines whose data bit is 0 keep their mask. The mask state reads back at 0x070 + 4·w.
- R3: For a level-triggered line, the pending bit (read at 0x0D0 + 4·w) equals the input one clock after it is sampled. The input is taken as is when the polarity bit is 1 and inverted when it is 0.
- R4: For an edge-triggered line with dual-edge off, a rising input edge (polarity 1) or a falling input edge (polarity 0) sets the pending bit one clock later. The bit then stays set until a clear command reaches it.
- R5: For an edge-triggered line with dual-edge on (dual word at 0x050, trigger word at 0x030, polarity word at 0x010), either input edge sets the pending bit, whatever the polarity bit holds.
- R6: A write to the command register (0x004) names a line in bits [7:0] and carries the action in bit 31: 1 sets that line's pending bit, 0 clears it. The command has no effect on level-triggered lines or on line numbers at or above the line count. A hardware edge in the same clock as a clear command wins, so the bit stays set.
- R7: The route register of line i (0x600 + 4·i) holds one bit per core. A write stores only the lowest set bit of the data, and a write of all zeros is ignored. core_req[c] is high exactly when some line is pending, unmasked and routed to core c.
- R8: The per-core winner register (0x100 + 4·c) reads the lowest line index that is pending, unmasked and routed to core c. It reads the line count when no line qualifies.
- R9: The pin register of line i (0x200 + 4·i) holds an enable in bit 31 and a pin number in its low bits. core_pin_req[c·NUM_PINS + p] is high exactly when some enabled line assigned to pin p is pending, unmasked and routed to core c.
- R10: The read-only configuration word (0x000) gives NUM_LINES/8 − 1 in bits [23:16] and NUM_CORES − 1 in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | External interrupt lines, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_req | output | NUM_CORES | Per-core interrupt request |
| core_pin_req | output | NUM_CORES*NUM_PINS | Per-core, per-pin interrupt request |

## Verification
Every line runs through pseudo-random input sequences under each uniform sense mode and under one mixed mode. If polarity were swapped, or a dual-edge line still looked at polarity, or level mode latched its value, the pending word would drift from the arithmetic model. The command register is checked with an out-of-range line number whose low bits alias line 8, so a truncating decoder would set line 8 in error. It is also checked against a clear that lands in the same clock as a rising edge, where a design that gave the clear priority would lose the interrupt. The winner register is checked as pending bits fill in from the top line down and again after masking, so a scan from the wrong end would report the highest line and a missing sentinel would report 0. Routing writes with two bits set and with no bits set show whether the one-hot rule holds.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

    // Register word indices (byte address / 4)
    localparam int WA_CFG   = 0;
    localparam int WA_CMD   = 1;
    localparam int WA_POL   = 4;
    localparam int WA_TRIG  = 12;
    localparam int WA_DUAL  = 20;
    localparam int WA_MASK  = 28;
    localparam int WA_SETM  = 36;
    localparam int WA_CLRM  = 44;
    localparam int WA_PEND  = 52;
    localparam int WA_WIN   = 64;
    localparam int WA_PIN   = 128;
    localparam int WA_ROUTE = 384;

    localparam int CMD_SET_BIT = 31;
    localparam int PIN_EN_BIT  = 31;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    typedef struct packed {
        logic  pol;
        trig_e trig;
        logic  dual;
    } line_cfg_t;

endpackage

// File: rtl/shirq_line.sv
module shirq_line
    import shirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_in,
    input  line_cfg_t cfg,
    input  logic      cmd_hit,
    input  logic      cmd_set,
    output logic      pend_o
);

    logic prev_q;
    logic pend_q;
    logic qual;
    logic rise;
    logic fall;
    logic edge_hit;

    always_comb begin
        qual     = cfg.pol ? line_in : ~line_in;
        rise     = line_in & ~prev_q;
        fall     = ~line_in & prev_q;
        edge_hit = cfg.dual ? (rise | fall) : (cfg.pol ? rise : fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= line_in;
            unique case (cfg.trig)
                TRIG_LEVEL: pend_q <= qual;
                TRIG_EDGE: begin
                    if (edge_hit || (cmd_hit && cmd_set))
                        pend_q <= 1'b1;
                    else if (cmd_hit)
                        pend_q <= 1'b0;
                end
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend_o = pend_q;

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.trig == TRIG_LEVEL) |=> (pend_q == $past(qual))); // R3

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.trig == TRIG_EDGE && pend_q && !(cmd_hit && !cmd_set)) |=> pend_q); // R4

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.trig == TRIG_EDGE && edge_hit) |=> pend_q); // R6

    AST_DUAL_ANY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.trig == TRIG_EDGE && cfg.dual && (line_in != prev_q)) |=> pend_q); // R5

endmodule

// File: rtl/shirq_pick.sv
module shirq_pick #(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] hits,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 any_o
);

    always_comb begin
        idx_o = IDX_W'(NUM_LINES);
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (hits[i])
                idx_o = IDX_W'(i);
        end
        any_o = |hits;
    end

    AST_PICK_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> hits[idx_o]); // R8

    AST_PICK_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (idx_o == IDX_W'(NUM_LINES))); // R8

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ($countones(hits & ~({NUM_LINES{1'b1}} << idx_o)) == 0)); // R8

endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
    import shirq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_CORES = 2,
    parameter int NUM_PINS  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          irq_in,
    input  logic                          bus_wr,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic [NUM_CORES-1:0]          core_req,
    output logic [NUM_CORES*NUM_PINS-1:0] core_pin_req
);

    localparam int IDX_W      = $clog2(NUM_LINES + 1);
    localparam int PIN_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int LINE_WORDS = (NUM_LINES + 31) / 32;
    localparam int PADDED     = LINE_WORDS * 32;

    logic [9:0]                  waddr;
    logic [NUM_LINES-1:0]        pol_v, trig_v, dual_v, mask_v, pend_v, pin_en_v;
    logic [NUM_LINES*NUM_CORES-1:0] route_flat;
    logic [NUM_LINES*PIN_W-1:0]  pin_flat;
    logic [NUM_CORES-1:0]        route_pick;
    logic [NUM_CORES-1:0][NUM_LINES-1:0] hit_m;
    logic [NUM_CORES-1:0][IDX_W-1:0]     win_idx;
    logic [PADDED-1:0]           pol_pad, trig_pad, dual_pad, mask_pad, pend_pad;
    logic                        unused_bits;

    assign waddr       = bus_addr[11:2];
    assign route_pick  = bus_wdata[NUM_CORES-1:0] & (~bus_wdata[NUM_CORES-1:0] + NUM_CORES'(1));
    assign unused_bits = ^{bus_addr, bus_wdata};

    // Per-line configuration, routing and pending state
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic [9:0] A_POL  = 10'(WA_POL + i / 32);
        localparam logic [9:0] A_TRIG = 10'(WA_TRIG + i / 32);
        localparam logic [9:0] A_DUAL = 10'(WA_DUAL + i / 32);
        localparam logic [9:0] A_SETM = 10'(WA_SETM + i / 32);
        localparam logic [9:0] A_CLRM = 10'(WA_CLRM + i / 32);
        localparam logic [9:0] A_PIN  = 10'(WA_PIN + i);
        localparam logic [9:0] A_RT   = 10'(WA_ROUTE + i);
        localparam logic [7:0] LID    = 8'(i);
        localparam int         B      = i % 32;

        logic                 pol_q, dual_q, mask_q, pin_en_q;
        trig_e                trig_q;
        logic [PIN_W-1:0]     pin_q;
        logic [NUM_CORES-1:0] route_q;
        line_cfg_t            cfg;
        logic                 cmd_hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pol_q    <= 1'b1;
                trig_q   <= TRIG_LEVEL;
                dual_q   <= 1'b0;
                mask_q   <= 1'b0;
                pin_en_q <= 1'b0;
                pin_q    <= '0;
                route_q  <= NUM_CORES'(1);
            end else if (bus_wr) begin
                if (waddr == A_POL)  pol_q  <= bus_wdata[B];
                if (waddr == A_TRIG) trig_q <= trig_e'(bus_wdata[B]);
                if (waddr == A_DUAL) dual_q <= bus_wdata[B];
                if (waddr == A_SETM && bus_wdata[B])
                    mask_q <= 1'b1;
                else if (waddr == A_CLRM && bus_wdata[B])
                    mask_q <= 1'b0;
                if (waddr == A_PIN) begin
                    pin_en_q <= bus_wdata[PIN_EN_BIT];
                    pin_q    <= bus_wdata[PIN_W-1:0];
                end
                if (waddr == A_RT && |bus_wdata[NUM_CORES-1:0])
                    route_q <= route_pick;
            end
        end

        assign cfg     = '{pol: pol_q, trig: trig_q, dual: dual_q};
        assign cmd_hit = bus_wr && (waddr == 10'(WA_CMD)) && (bus_wdata[7:0] == LID);

        shirq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (irq_in[i]),
            .cfg     (cfg),
            .cmd_hit (cmd_hit),
            .cmd_set (bus_wdata[CMD_SET_BIT]),
            .pend_o  (pend_v[i])
        );

        assign pol_v[i]    = pol_q;
        assign trig_v[i]   = (trig_q == TRIG_EDGE);
        assign dual_v[i]   = dual_q;
        assign mask_v[i]   = mask_q;
        assign pin_en_v[i] = pin_en_q;
        assign pin_flat[i*PIN_W +: PIN_W]           = pin_q;
        assign route_flat[i*NUM_CORES +: NUM_CORES] = route_q;

        AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(route_q) == 1); // R7

        AST_SETMASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && waddr == A_SETM && bus_wdata[B]) |=> mask_q); // R2

        AST_CLRMASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && waddr == A_CLRM && bus_wdata[B]) |=> !mask_q); // R2
    end

    // Per-core qualification, priority pick and pin fan-out
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
            assign hit_m[c][i] = pend_v[i] & mask_v[i] & route_flat[i*NUM_CORES + c];
        end

        shirq_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .hits  (hit_m[c]),
            .idx_o (win_idx[c]),
            .any_o (core_req[c])
        );

        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [NUM_LINES-1:0] on_pin;
            for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
                assign on_pin[i] = pin_en_v[i] && (pin_flat[i*PIN_W +: PIN_W] == PIN_W'(p));
            end
            assign core_pin_req[c*NUM_PINS + p] = |(hit_m[c] & on_pin);
        end

        AST_REQ_MATCHES_HITS: assert property (@(posedge clk) disable iff (!rst_n)
            core_req[c] == (hit_m[c] != '0)); // R7
    end

    // Read path
    always_comb begin
        pol_pad  = '0; pol_pad[NUM_LINES-1:0]  = pol_v;
        trig_pad = '0; trig_pad[NUM_LINES-1:0] = trig_v;
        dual_pad = '0; dual_pad[NUM_LINES-1:0] = dual_v;
        mask_pad = '0; mask_pad[NUM_LINES-1:0] = mask_v;
        pend_pad = '0; pend_pad[NUM_LINES-1:0] = pend_v;
    end

    always_comb begin
        bus_rdata = '0;
        if (waddr == 10'(WA_CFG)) begin
            bus_rdata[23:16] = 8'(NUM_LINES / 8 - 1);
            bus_rdata[7:0]   = 8'(NUM_CORES - 1);
        end
        for (int w = 0; w < LINE_WORDS; w++) begin
            if (waddr == 10'(WA_POL + w))  bus_rdata = pol_pad[w*32 +: 32];
            if (waddr == 10'(WA_TRIG + w)) bus_rdata = trig_pad[w*32 +: 32];
            if (waddr == 10'(WA_DUAL + w)) bus_rdata = dual_pad[w*32 +: 32];
            if (waddr == 10'(WA_MASK + w)) bus_rdata = mask_pad[w*32 +: 32];
            if (waddr == 10'(WA_PEND + w)) bus_rdata = pend_pad[w*32 +: 32];
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (waddr == 10'(WA_WIN + c)) bus_rdata = 32'(win_idx[c]);
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (waddr == 10'(WA_PIN + i))
                bus_rdata = {pin_en_v[i], 31'(pin_flat[i*PIN_W +: PIN_W])};
            if (waddr == 10'(WA_ROUTE + i))
                bus_rdata = 32'(route_flat[i*NUM_CORES +: NUM_CORES]);
        end
    end

endmodule

// File: tb/shirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module shirq_ctrl_tb_top;

    localparam int N = 32;
    localparam int C = 2;
    localparam int P = 6;

    localparam logic [11:0] AD_CFG = 12'h000, AD_CMD = 12'h004, AD_POL = 12'h010,
                            AD_TRIG = 12'h030, AD_DUAL = 12'h050, AD_MASK = 12'h070,
                            AD_SETM = 12'h090, AD_CLRM = 12'h0B0, AD_PEND = 12'h0D0,
                            AD_WIN = 12'h100, AD_PIN = 12'h200, AD_RT = 12'h600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [C-1:0]  core_req;
    logic [C*P-1:0] core_pin_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] pol_m, trig_m, dual_m, pend_m, mask_m, prev_m, lfsr;
    int          route_m [N];

    always #2 clk = ~clk;

    shirq_ctrl #(.NUM_LINES(N), .NUM_CORES(C), .NUM_PINS(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_req(core_req), .core_pin_req(core_pin_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    function automatic int lowest(input logic [31:0] h);
        for (int i = 0; i < N; i++) if (h[i]) return i;
        return N;
    endfunction

    function automatic logic [31:0] core_hits(input int c);
        logic [31:0] h = '0;
        for (int i = 0; i < N; i++) h[i] = pend_m[i] & mask_m[i] & (route_m[i] == c);
        return h;
    endfunction

    task automatic step(input logic [31:0] v, input string tag);
        logic [31:0] d;
        @(negedge clk); irq_in = v;
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) begin
            logic q, r, f, e;
            q = pol_m[i] ? v[i] : ~v[i];
            r = v[i] & ~prev_m[i];
            f = ~v[i] & prev_m[i];
            e = dual_m[i] ? (r | f) : (pol_m[i] ? r : f);
            if (!trig_m[i]) pend_m[i] = q;
            else if (e) pend_m[i] = 1'b1;
        end
        prev_m = v;
        rd(AD_PEND, d);
        chk(tag, d, pend_m);
    endtask

    task automatic setup_mode(input logic [31:0] p, input logic [31:0] t,
                              input logic [31:0] du, input string tag);
        logic [31:0] d;
        @(negedge clk); irq_in = '0;
        repeat (2) @(posedge clk);
        wr(AD_POL, p); wr(AD_TRIG, t); wr(AD_DUAL, du);
        for (int i = 0; i < N; i++) wr(AD_CMD, 32'(i));
        pol_m = p; trig_m = t; dual_m = du; prev_m = '0;
        pend_m = ~t & ~p;
        rd(AD_PEND, d);
        chk(tag, d, pend_m);
    endtask

    task automatic sweep(input logic [31:0] p, input logic [31:0] t,
                         input logic [31:0] du, input string tag);
        logic [31:0] d;
        setup_mode(p, t, du, tag);
        for (int s = 0; s < 16; s++) begin
            lfsr = nxt(lfsr);
            step(lfsr, tag);
        end
        for (int i = 0; i < N; i += 2) begin
            wr(AD_CMD, 32'(i));
            if (trig_m[i]) pend_m[i] = 1'b0;
        end
        rd(AD_PEND, d);
        chk({tag, " after clears"}, d, pend_m);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        lfsr = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R10: reset values and configuration word
        rd(AD_CFG, d);  chk("R10 config word", d, 32'h0003_0001);
        rd(AD_POL, d);  chk("R1 polarity", d, 32'hFFFF_FFFF);
        rd(AD_TRIG, d); chk("R1 trigger", d, 32'h0);
        rd(AD_DUAL, d); chk("R1 dual", d, 32'h0);
        rd(AD_MASK, d); chk("R1 mask", d, 32'h0);
        rd(AD_PEND, d); chk("R1 pending", d, 32'h0);
        rd(AD_PIN, d);  chk("R1 pin line0", d, 32'h0);
        for (int i = 0; i < N; i++) begin
            rd(AD_RT + 12'(4 * i), d); chk("R1 route", d, 32'h1);
        end
        for (int c = 0; c < C; c++) begin
            rd(AD_WIN + 12'(4 * c), d); chk("R1 winner", d, 32'(N));
        end
        chk("R1 core_req", 32'(core_req), 32'h0);
        chk("R1 core_pin_req", 32'(core_pin_req), 32'h0);

        // R2: write-one set and clear of masks
        wr(AD_SETM, 32'hA5A5_0F0F); rd(AD_MASK, d); chk("R2 set mask", d, 32'hA5A5_0F0F);
        wr(AD_CLRM, 32'h0000_0F00); rd(AD_MASK, d); chk("R2 clear mask", d, 32'hA5A5_000F);
        wr(AD_SETM, 32'h0);         rd(AD_MASK, d); chk("R2 zero set", d, 32'hA5A5_000F);
        wr(AD_CLRM, 32'h0);         rd(AD_MASK, d); chk("R2 zero clear", d, 32'hA5A5_000F);
        wr(AD_CLRM, 32'hFFFF_FFFF); rd(AD_MASK, d); chk("R2 clear all", d, 32'h0);

        // R3 / R4 / R5: mode sweeps against arithmetic model
        sweep(32'hFFFF_FFFF, 32'h0, 32'h0, "R3 level high");
        sweep(32'h0, 32'h0, 32'h0, "R3 level low");
        sweep(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R4 rising");
        sweep(32'h0, 32'hFFFF_FFFF, 32'h0, "R4 falling");
        sweep(32'h6C3A_91E5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 dual edge");
        sweep(32'h3C3C_5A5A, 32'hF0F0_CC33, 32'h0FF0_0F0F, "R3 R4 R5 mixed");

        // R6: command register
        setup_mode(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R6 setup");
        wr(AD_CMD, 32'h8000_0007); rd(AD_PEND, d); chk("R6 set line 7", d, 32'h0000_0080);
        wr(AD_CMD, 32'h8000_0028); rd(AD_PEND, d); chk("R6 out-of-range line", d, 32'h0000_0080);
        wr(AD_CMD, 32'h0000_0007); rd(AD_PEND, d); chk("R6 clear line 7", d, 32'h0);
        wr(AD_CMD, 32'h8000_0003);
        @(negedge clk);
        irq_in = 32'h8; bus_wr = 1'b1; bus_addr = AD_CMD; bus_wdata = 32'h0000_0003;
        @(posedge clk); #1 bus_wr = 1'b0;
        rd(AD_PEND, d); chk("R6 edge beats clear", d, 32'h8);
        wr(AD_CMD, 32'h0000_0003); rd(AD_PEND, d); chk("R6 clear without edge", d, 32'h0);
        @(negedge clk); irq_in = '0;
        wr(AD_TRIG, 32'hFFFF_FFFE);
        wr(AD_CMD, 32'h8000_0000); rd(AD_PEND, d); chk("R6 level line ignores set", d, 32'h0);
        wr(AD_TRIG, 32'hFFFF_FFFF);

        // R7 / R8: routing, requests and lowest-index pick
        setup_mode(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R7 setup");
        wr(AD_SETM, 32'hFFFF_FFFF); mask_m = 32'hFFFF_FFFF;
        for (int i = 0; i < N; i++) begin
            logic [31:0] v;
            v = (i == 4) ? 32'h3 : (i == 5) ? 32'h0 : ((i % 2 == 0) ? 32'h1 : 32'h2);
            wr(AD_RT + 12'(4 * i), v);
            route_m[i] = (i == 4 || i == 5) ? 0 : (i % 2);
        end
        rd(AD_RT + 12'(16), d); chk("R7 two bits keep lowest", d, 32'h1);
        rd(AD_RT + 12'(20), d); chk("R7 zero write ignored", d, 32'h1);
        rd(AD_RT + 12'(28), d); chk("R7 route line 7", d, 32'h2);
        chk("R7 idle core_req", 32'(core_req), 32'h0);
        for (int j = N - 1; j >= 0; j--) begin
            wr(AD_CMD, 32'h8000_0000 | 32'(j));
            pend_m[j] = 1'b1;
            for (int c = 0; c < C; c++) begin
                rd(AD_WIN + 12'(4 * c), d);
                chk("R8 winner fill", d, 32'(lowest(core_hits(c))));
                chk("R7 core_req fill", 32'(core_req[c]), 32'(core_hits(c) != 0));
            end
        end
        wr(AD_CLRM, 32'h0000_FFFF); mask_m = 32'hFFFF_0000;
        for (int c = 0; c < C; c++) begin
            rd(AD_WIN + 12'(4 * c), d);
            chk("R8 winner masked", d, 32'(lowest(core_hits(c))));
        end
        wr(AD_CLRM, 32'hFFFF_FFFF); mask_m = '0;
        for (int c = 0; c < C; c++) begin
            rd(AD_WIN + 12'(4 * c), d);
            chk("R8 winner none", d, 32'(N));
        end
        chk("R7 all masked core_req", 32'(core_req), 32'h0);

        // R9: pin assignment
        wr(AD_SETM, 32'hFFFF_0000); mask_m = 32'hFFFF_0000;
        wr(AD_PIN + 12'(4 * 20), 32'h8000_0003);
        wr(AD_PIN + 12'(4 * 21), 32'h8000_0005);
        rd(AD_PIN + 12'(4 * 20), d); chk("R9 pin readback", d, 32'h8000_0003);
        chk("R9 two pins", 32'(core_pin_req), 32'((1 << 3) | (1 << (P + 5))));
        wr(AD_PIN + 12'(4 * 20), 32'h0000_0003);
        chk("R9 disabled pin", 32'(core_pin_req), 32'(1 << (P + 5)));
        wr(AD_CLRM, 32'h0020_0000);
        chk("R9 masked pin", 32'(core_pin_req), 32'h0);

        done = 1;
        summary();
    end

endmodule